// File: doc/BRIEF.md
# Way-Partitioned Cache Allocation Controller

This block is the tag side of a set-associative last-level cache whose ways are shared out among requesters. Each request brings a physical line address and a class-of-service number. The block looks the address up in every way of its set and reports a hit together with the way. On a miss it picks a fill victim, and it may take that victim only from the ways that the requester's class is allowed to allocate into. The data array, coherence and memory traffic sit outside this block. A surrounding cache controller uses the reported way to steer its data array.

Each class owns a capacity bitmask with one bit per way. A cleared bit keeps that class out of the way when a fill is placed. Lookups ignore the masks, so a line that another class placed is still shared as a hit. Masks are loaded through a small write port. A single-cycle invalidate input sweeps the valid bits one set per cycle. While the sweep runs, the block holds off requests.

The defaults are 64-byte lines, 16 ways, 64 sets, a 32-bit address and four classes. The set count is a parameter and can be raised for a full-size array, for example to 8192 sets indexed by address bits [18:6].

Top module: `cache_way_partition_ctrl`

## Requirements
- R1: Address bits [5:0] select a byte within the line and play no part in lookup. The set index is the next log2(SETS) bits, which are bits [11:6] by default. The tag is all bits above the set index. Two addresses that differ only by a multiple of SETS*64 map to the same set.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `resp_valid` is high in exactly the cycle that follows each accepted request and low at all other times.
- R3: The tag is compared against every valid way of the set, whatever the class mask. A match gives `resp_hit`=1, `resp_fill`=0 and `resp_way` equal to the matching way.
- R4: On a miss with a non-zero mask, the victim is the lowest-indexed way that is both permitted and invalid. The response then gives `resp_hit`=0, `resp_fill`=1 and `resp_way` equal to that victim.
- R5: When every permitted way is valid, the victim comes from a per-set tree pseudo-LRU. The tree nodes are heap-numbered from 1 to WAYS-1. A node bit of 0 steers the walk toward the lower-numbered half of the ways and a bit of 1 toward the upper half. If the steered half holds no permitted way, the walk takes the other half.
- R6: A fill never lands in a way whose bit is clear in the class mask that was in force when the request was accepted.
- R7: A miss whose class mask is all zero gives `resp_hit`=0 and `resp_fill`=0. It leaves the valid bits, the tags and the replacement state of the set unchanged.
- R8: A hit or a fill sets every tree node on the path to the accessed way so that it points away from that way. A request accepted in the very next cycle already sees the updated state.
- R9: There are four classes, chosen by `req_cos` (2 bits), and each mask resets to all ones. A write through `cfg_we` applies to requests accepted from the next cycle onward.
- R10: A pulse on `inval_req` while `req_ready` is high drives `req_ready` low for exactly SETS cycles, starting in the next cycle. After that, every line is invalid and the pseudo-LRU state is kept.
- R11: After reset, `req_ready` is 1, `resp_valid` is 0 and no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Low while an invalidate sweep runs |
| req_addr | input | ADDR_W | Physical byte address |
| req_cos | input | COS_W | Class of service of the request |
| resp_valid | output | 1 | Result of the request accepted in the previous cycle |
| resp_hit | output | 1 | The line was resident |
| resp_fill | output | 1 | The line was allocated into `resp_way` |
| resp_way | output | log2(WAYS) | Hit way or fill way |
| cfg_we | input | 1 | Write strobe for a class mask |
| cfg_cos | input | COS_W | Class whose mask is written |
| cfg_mask | input | WAYS | New capacity bitmask |
| inval_req | input | 1 | Start an invalidate-all sweep |

## Verification
The assertions assume that the environment changes a class mask only through `cfg_we`, since a shadow copy of the masks is kept from that port. They also assume that `inval_req` is a single-cycle pulse given while the block is ready. The bench keeps mask writes and invalidate pulses in cycles that carry no request, and it raises `req_valid` only when its model expects `req_ready` high. The random phase confines addresses to a few sets and a few dozen tags, so that hits, evictions under narrow masks and zero-mask misses all occur often.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

    // Outcome of one accepted request, carried to the response stage
    typedef enum logic [1:0] {
        OUT_NONE   = 2'd0,
        OUT_HIT    = 2'd1,
        OUT_FILL   = 2'd2,
        OUT_BYPASS = 2'd3
    } outcome_e;

    localparam int MAX_WAYS = 64;

    // Index of the lowest set bit among the first n bits, -1 if none
    function automatic int first_one(input logic [MAX_WAYS-1:0] v, input int n);
        int idx;
        idx = -1;
        for (int i = n - 1; i >= 0; i--) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/cwp_mask_bank.sv
module cwp_mask_bank #(
    parameter int WAYS  = 16,
    parameter int COS_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [COS_W-1:0] wr_cos,
    input  logic [WAYS-1:0]  wr_mask,
    input  logic [COS_W-1:0] rd_cos,
    output logic [WAYS-1:0]  rd_mask
);
    localparam int NCLASS = 1 << COS_W;

    logic [WAYS-1:0] bank [NCLASS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCLASS; c++) bank[c] <= '1;
        end else if (wr_en) begin
            bank[wr_cos] <= wr_mask;
        end
    end

    assign rd_mask = bank[rd_cos];
endmodule

// File: rtl/cwp_tag_store.sv
module cwp_tag_store #(
    parameter int SETS  = 64,
    parameter int WAYS  = 16,
    parameter int TAG_W = 20,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
    output logic [WAYS-1:0]             rd_valid,
    input  logic                        fill_en,
    input  logic [SET_W-1:0]            fill_set,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic                        clr_en,
    input  logic [SET_W-1:0]            clr_set
);
    logic [WAYS-1:0][TAG_W-1:0] tag_mem [SETS];
    logic [WAYS-1:0]            vld_mem [SETS];

    // Tags need no reset: a tag is only compared when its valid bit is set
    always_ff @(posedge clk) begin
        if (fill_en) tag_mem[fill_set][fill_way] <= fill_tag;
    end

    // Sweep clears and fills never coincide: requests stall during a sweep
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
        end else if (clr_en) begin
            vld_mem[clr_set] <= '0;
        end else if (fill_en) begin
            vld_mem[fill_set][fill_way] <= 1'b1;
        end
    end

    assign rd_tags  = tag_mem[rd_set];
    assign rd_valid = vld_mem[rd_set];
endmodule

// File: rtl/cwp_plru.sv
module cwp_plru #(
    parameter int SETS = 64,
    parameter int WAYS = 16,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] sel_set,
    input  logic [WAYS-1:0]  sel_mask,
    output logic [WAY_W-1:0] victim,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way
);
    // Heap-numbered tree nodes 1..WAYS-1; 0 steers low, 1 steers high
    logic [WAYS-1:1] tree [SETS];
    logic [WAYS-1:1] cur_tree;
    logic [WAYS-1:1] next_tree;

    assign cur_tree = tree[sel_set];

    // Mask-aware walk from the root down to a leaf
    always_comb begin
        int  node;
        int  lo;
        int  span;
        int  half;
        logic low_any;
        logic high_any;
        logic go_high;
        node = 1;
        lo   = 0;
        span = WAYS;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            half     = span / 2;
            low_any  = 1'b0;
            high_any = 1'b0;
            for (int j = 0; j < WAYS; j++) begin
                if (j >= lo && j < lo + half && sel_mask[j])         low_any  = 1'b1;
                if (j >= lo + half && j < lo + span && sel_mask[j])  high_any = 1'b1;
            end
            go_high = cur_tree[node];
            if (go_high && !high_any)     go_high = 1'b0;
            else if (!go_high && !low_any) go_high = 1'b1;
            if (go_high) lo = lo + half;
            node = 2 * node + (go_high ? 1 : 0);
            span = half;
        end
        victim = lo[WAY_W-1:0];
    end

    // Point every node on the path away from the accessed way
    always_comb begin
        int node;
        next_tree = tree[upd_set];
        node = 1;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            next_tree[node] = ~upd_way[WAY_W-1-lvl];
            node = 2 * node + (upd_way[WAY_W-1-lvl] ? 1 : 0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) tree[s] <= '0;
        end else if (upd_en) begin
            tree[upd_set] <= next_tree;
        end
    end
endmodule

// File: rtl/cwp_sweeper.sv
module cwp_sweeper #(
    parameter int SETS = 64,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic [SET_W-1:0] clr_set
);
    localparam logic [SET_W-1:0] LAST = SET_W'(SETS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            clr_set <= '0;
        end else if (busy) begin
            if (clr_set == LAST) begin
                busy    <= 1'b0;
                clr_set <= '0;
            end else begin
                clr_set <= clr_set + 1'b1;
            end
        end else if (start) begin
            busy    <= 1'b1;
            clr_set <= '0;
        end
    end
endmodule

// File: rtl/cache_way_partition_ctrl.sv
module cache_way_partition_ctrl
    import cwp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 64,
    parameter int WAYS       = 16,
    parameter int COS_W      = 2,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [COS_W-1:0]  req_cos,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_fill,
    output logic [WAY_W-1:0]  resp_way,
    input  logic              cfg_we,
    input  logic [COS_W-1:0]  cfg_cos,
    input  logic [WAYS-1:0]   cfg_mask,
    input  logic              inval_req
);
    // Address split
    logic [SET_W-1:0] a_set;
    logic [TAG_W-1:0] a_tag;
    logic             unused_offset;
    assign a_set         = req_addr[OFF_W +: SET_W];
    assign a_tag         = req_addr[ADDR_W-1 -: TAG_W];
    assign unused_offset = ^req_addr[OFF_W-1:0];

    logic             accept;
    logic             sweep_busy;
    logic [SET_W-1:0] sweep_set;
    assign req_ready = !sweep_busy;
    assign accept    = req_valid && req_ready;

    logic [WAYS-1:0] perm;
    cwp_mask_bank #(.WAYS(WAYS), .COS_W(COS_W)) u_masks (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_cos(cfg_cos), .wr_mask(cfg_mask),
        .rd_cos(req_cos), .rd_mask(perm)
    );

    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0]            set_valid;
    logic                       fill_en;
    logic [WAY_W-1:0]           victim;

    cwp_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst),
        .rd_set(a_set), .rd_tags(set_tags), .rd_valid(set_valid),
        .fill_en(fill_en), .fill_set(a_set), .fill_way(victim), .fill_tag(a_tag),
        .clr_en(sweep_busy), .clr_set(sweep_set)
    );

    cwp_sweeper #(.SETS(SETS)) u_sweep (
        .clk(clk), .rst(rst),
        .start(inval_req), .busy(sweep_busy), .clr_set(sweep_set)
    );

    // Lookup over every valid way, regardless of the class mask
    logic [WAYS-1:0] hit_vec;
    logic            hit;
    logic [WAY_W-1:0] hit_way;
    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign hit_vec[w] = set_valid[w] && (set_tags[w] == a_tag);
        end
    endgenerate

    // Victim: lowest permitted invalid way, else mask-aware tree walk
    logic [WAYS-1:0]  free_vec;
    logic [WAY_W-1:0] plru_way;
    logic [WAY_W-1:0] free_way;
    logic             has_free;
    logic             can_fill;
    int               hit_idx;
    int               free_idx;

    assign free_vec = perm & ~set_valid;
    assign can_fill = |perm;

    always_comb begin
        hit_idx  = first_one(MAX_WAYS'(hit_vec), WAYS);
        free_idx = first_one(MAX_WAYS'(free_vec), WAYS);
        hit      = (hit_idx >= 0);
        has_free = (free_idx >= 0);
        hit_way  = hit ? hit_idx[WAY_W-1:0] : '0;
        free_way = has_free ? free_idx[WAY_W-1:0] : '0;
    end

    assign victim  = has_free ? free_way : plru_way;
    assign fill_en = accept && !hit && can_fill;

    logic             touch_en;
    logic [WAY_W-1:0] touch_way;
    assign touch_en  = accept && (hit || can_fill);
    assign touch_way = hit ? hit_way : victim;

    cwp_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk(clk), .rst(rst),
        .sel_set(a_set), .sel_mask(perm), .victim(plru_way),
        .upd_en(touch_en), .upd_set(a_set), .upd_way(touch_way)
    );

    // Response stage
    outcome_e         out_q;
    logic [WAY_W-1:0] way_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= OUT_NONE;
            way_q <= '0;
        end else if (accept) begin
            out_q <= hit ? OUT_HIT : (can_fill ? OUT_FILL : OUT_BYPASS);
            way_q <= touch_way;
        end else begin
            out_q <= OUT_NONE;
        end
    end

    assign resp_valid = (out_q != OUT_NONE);
    assign resp_hit   = (out_q == OUT_HIT);
    assign resp_fill  = (out_q == OUT_FILL);
    assign resp_way   = way_q;
endmodule

// File: rtl/cwp_checker.sv
module cwp_checker #(
    parameter int WAYS  = 16,
    parameter int COS_W = 2,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int NCLASS = 1 << COS_W
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [COS_W-1:0] req_cos,
    input logic             cfg_we,
    input logic [COS_W-1:0] cfg_cos,
    input logic [WAYS-1:0]  cfg_mask,
    input logic             inval_req,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic             resp_fill,
    input logic [WAY_W-1:0] resp_way
);
    // Shadow masks rebuilt from the write port, and the mask seen at acceptance
    logic [WAYS-1:0] shadow [NCLASS];
    logic [WAYS-1:0] cap_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCLASS; c++) shadow[c] <= '1;
            cap_mask <= '1;
        end else begin
            if (cfg_we) shadow[cfg_cos] <= cfg_mask;
            if (req_valid && req_ready) cap_mask <= shadow[req_cos];
        end
    end

    p_resp_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> resp_valid);

    p_no_stray_resp_r2: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !resp_valid);

    p_hit_fill_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !(resp_hit && resp_fill));

    p_miss_allocates_r4: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit && cap_mask != '0) |-> resp_fill);

    p_fill_in_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fill) |-> cap_mask[resp_way]);

    p_zero_mask_no_fill_r7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && cap_mask == '0) |-> !resp_fill);

    p_inval_stalls_r10: assert property (@(posedge clk) disable iff (rst)
        (inval_req && req_ready) |=> !req_ready);
endmodule

bind cache_way_partition_ctrl cwp_checker #(.WAYS(WAYS), .COS_W(COS_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cos(req_cos), .cfg_we(cfg_we), .cfg_cos(cfg_cos), .cfg_mask(cfg_mask),
    .inval_req(inval_req), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_fill(resp_fill), .resp_way(resp_way)
);

// File: tb/tb_cache_way_partition_ctrl.sv
module tb_cache_way_partition_ctrl;
    localparam int SETS = 64;
    localparam int WAYS = 16;
    localparam int LOGW = 4;
    localparam int SETB = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [31:0] req_addr;
    logic [1:0]  req_cos;
    logic        resp_valid, resp_hit, resp_fill;
    logic [3:0]  resp_way;
    logic        cfg_we;
    logic [1:0]  cfg_cos;
    logic [15:0] cfg_mask;
    logic        inval_req;

    always #5 clk = ~clk;

    cache_way_partition_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_cos(req_cos), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_fill(resp_fill), .resp_way(resp_way),
        .cfg_we(cfg_we), .cfg_cos(cfg_cos), .cfg_mask(cfg_mask), .inval_req(inval_req)
    );

    int nchecks = 0;
    int nfail   = 0;
    bit done    = 0;

    // Behavioural reference state
    int unsigned mtag  [SETS][WAYS];
    bit          mval  [SETS][WAYS];
    bit          mtree [SETS][WAYS];
    int          mmask [4];

    task automatic check(input string req, input string what, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int unsigned mk_addr(int s, int t, int off);
        return (t << (6 + SETB)) | (s << 6) | (off & 63);
    endfunction

    function automatic bit any_in(int msk, int lo, int n);
        for (int k = lo; k < lo + n; k++) if ((msk >> k) & 1) return 1;
        return 0;
    endfunction

    function automatic int tree_pick(int s, int msk);
        int node = 1, lo = 0, span = WAYS;
        while (span > 1) begin
            int half = span / 2;
            bit up = mtree[s][node];
            if (up && !any_in(msk, lo + half, half)) up = 0;
            else if (!up && !any_in(msk, lo, half)) up = 1;
            if (up) lo += half;
            node = node * 2 + up;
            span = half;
        end
        return lo;
    endfunction

    function automatic void touch(int s, int w);
        int node = 1;
        for (int l = LOGW - 1; l >= 0; l--) begin
            int b = (w >> l) & 1;
            mtree[s][node] = (b == 0);
            node = node * 2 + b;
        end
    endfunction

    // One request: drive at a falling edge, compare at the next falling edge
    task automatic do_req(input int unsigned addr, input int cos, input string tagname);
        int s = (addr >> 6) % SETS;
        int unsigned t = addr >> (6 + SETB);
        int msk = mmask[cos];
        int e_hit = 0, e_fill = 0, e_way = 0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (mval[s][w] && mtag[s][w] == t) begin e_hit = 1; e_way = w; end
        if (!e_hit && msk != 0) begin
            int fr = -1;
            for (int w = WAYS - 1; w >= 0; w--)
                if (((msk >> w) & 1) && !mval[s][w]) fr = w;
            e_fill = 1;
            e_way  = (fr >= 0) ? fr : tree_pick(s, msk);
            mval[s][e_way] = 1;
            mtag[s][e_way] = t;
        end
        if (e_hit || e_fill) touch(s, e_way);
        check(tagname, "ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = addr;
        req_cos   = 2'(cos);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "resp_valid", int'(resp_valid), 1);
        check(tagname, "resp_hit", int'(resp_hit), e_hit);
        check(tagname, "resp_fill", int'(resp_fill), e_fill);
        if (e_hit || e_fill) check(tagname, "resp_way", int'(resp_way), e_way);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R2", "resp_valid when idle", int'(resp_valid), 0);
        end
    endtask

    task automatic set_mask(input int cos, input int msk);
        cfg_we   = 1'b1;
        cfg_cos  = 2'(cos);
        cfg_mask = 16'(msk);
        @(negedge clk);
        cfg_we = 1'b0;
        mmask[cos] = msk;
    endtask

    task automatic invalidate();
        inval_req = 1'b1;
        @(negedge clk);
        inval_req = 1'b0;
        for (int i = 0; i < SETS; i++) begin
            check("R10", "ready during sweep", int'(req_ready), 0);
            @(negedge clk);
        end
        check("R10", "ready after sweep", int'(req_ready), 1);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) mval[s][w] = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            nchecks++;
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 0; req_addr = 0; req_cos = 0;
        cfg_we = 0; cfg_cos = 0; cfg_mask = 0; inval_req = 0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                mval[s][w] = 0; mtag[s][w] = 0; mtree[s][w] = 0;
            end
        for (int c = 0; c < 4; c++) mmask[c] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check("R11", "req_ready", int'(req_ready), 1);
        check("R11", "resp_valid", int'(resp_valid), 0);

        // R4: sixteen distinct tags in one set fill ways in ascending order
        for (int t = 1; t <= 16; t++) do_req(mk_addr(3, t, t), 0, "R4");
        // R1: different byte offset, same line
        do_req(mk_addr(3, 5, 63), 0, "R1");
        // R5/R8: full set, victims from the tree, back to back
        for (int t = 100; t < 106; t++) do_req(mk_addr(3, t, 0), 0, "R5");
        do_req(mk_addr(3, 100, 7), 0, "R8");

        // R9: narrow class 1 to ways 4..7; R6 fills stay inside
        set_mask(1, 16'h00F0);
        for (int t = 1; t <= 7; t++) do_req(mk_addr(9, t, 0), 1, "R6");
        // R3: line placed by class 0 in way 0 hits for class 1
        do_req(mk_addr(10, 7, 0), 0, "R4");
        do_req(mk_addr(10, 7, 12), 1, "R3");

        // R7: zero mask does not allocate and leaves the set alone
        set_mask(2, 0);
        do_req(mk_addr(10, 8, 0), 2, "R7");
        do_req(mk_addr(10, 8, 0), 0, "R7");
        idle(2);

        // R9: class 3 still all ones after reset; R1 aliasing by SETS*64
        for (int t = 0; t < 16; t++) do_req(mk_addr(11, t * 3 + 1, 0), 3, "R9");
        do_req(mk_addr(11, 4, 0) + SETS * 64 * 0, 3, "R1");

        // R10: sweep, then everything misses and fills from way 0
        invalidate();
        do_req(mk_addr(3, 5, 0), 0, "R10");
        do_req(mk_addr(11, 1, 0), 3, "R10");

        // Mixed traffic with changing masks
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 4) begin
                int m = ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(0, 16'hFFFF));
                set_mask(int'($urandom_range(0, 3)), m);
            end else if (r < 5 && i % 500 == 0) begin
                invalidate();
            end else if (r < 10) begin
                idle(1);
            end else begin
                do_req(mk_addr(int'($urandom_range(0, 3)) * 17, int'($urandom_range(0, 39)),
                               int'($urandom_range(0, 63))),
                       int'($urandom_range(0, 3)), "R5");
            end
        end
        idle(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end
endmodule